// File: doc/BRIEF.md
# Multi-Register Stack Push Sequencer

This block executes the "push a run of byte registers" instruction of a small 8-bit processor whose register file holds 16 bytes. A command carries an opcode byte and an operand byte. When the opcode is the push opcode, the sequencer reads registers one at a time through a single register-file read port. It writes each byte to memory below the current stack pointer and finally returns the lowered stack pointer on a write-back port, together with a one-cycle completion pulse.

The operand's upper nibble names the lowest register of the run and its lower nibble gives the run length minus one. Pushing starts at the top of the run and walks down to the base. Register indices wrap modulo 16, so a run that passes index 15 carries on at index 0. The two register slots that hold the stack pointer never supply live register-file data during a push. They supply a copy of the stack pointer taken when the command was accepted.

The command input is a valid/ready stream. `cmd_ready` is high only while the sequencer is idle, so a producer holding `cmd_valid` while a push is running is back-pressured and nothing is consumed. A command with any other opcode is consumed in one cycle and dropped. The memory side is a plain write strobe with a wait input: the sequencer holds address and data until a cycle in which wait is low.

Top module: `psh_multi_push`

## Requirements
- R1: `cmd_ready` is high only when idle. A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_valid` during a push has no effect on the writes or on the final stack pointer.
- R2: A command whose opcode is not 0x7E is consumed and causes no memory write, no stack-pointer write and no `done`.
- R3: The operand's bits 7:4 are the base index B and bits 3:0 are N-1. A push performs exactly N memory writes, with N from 1 to 16.
- R4: The k-th write (k = 0 to N-1) carries register index (B + N - 1 - k) mod 16, so the order runs from the highest index down to B.
- R5: The k-th write goes to address SP0 - 1 - k (mod 2^16), where SP0 is `sp_rdata` at acceptance: the pointer is lowered before each byte is stored.
- R6: A write for index 12 carries SP0[15:8] and a write for index 13 carries SP0[7:0], whatever the register file returns for those indices.
- R7: A run whose top passes index 15 wraps, so indices 0, 15 and 14 follow one another in that order within the push.
- R8: While `mem_wr` is high and `mem_wait` is high, the next cycle keeps `mem_wr` high with the same address and data. A byte counts as written only on a cycle where `mem_wait` is low.
- R9: After the last write, one cycle has `sp_we` high with `sp_wdata` = SP0 - N (mod 2^16) and `done` high. `done` is a single-cycle pulse, and the block is idle in the following cycle.
- R10: During and right after reset, `cmd_ready` is 1 and `mem_wr`, `sp_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_opcode | input | 8 | Instruction opcode byte |
| cmd_operand | input | 8 | Base index (7:4) and count minus one (3:0) |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 8 | Register-file read data, combinational on `rf_raddr` |
| sp_rdata | input | 16 | Current stack pointer |
| sp_we | output | 1 | Stack-pointer write-back strobe |
| sp_wdata | output | 16 | Final stack pointer |
| mem_wr | output | 1 | Memory write request |
| mem_wait | input | 1 | Memory not ready; hold the request |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 8 | Memory write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a push that passes through the stack-pointer slots while the memory stalls. Here a wrong design would show partly decremented pointer bytes or lose a byte across a held request. The stimulus table therefore includes a full 16-register run and a run from index 10 to 15, both containing indices 12 and 13. Several entries drive `mem_wait` from a shift-register pattern, so stalls land on varied bytes. The bench register file holds a marker value at the pointer slots so that any leak of live data is visible. A second command held high during a push, and a foreign opcode, are checked through the write log and `cmd_ready`.

// File: rtl/psh_pkg.sv
package psh_pkg;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_FETCH  = 2'd1,
    PS_WRITE  = 2'd2,
    PS_RETIRE = 2'd3
  } psh_state_e;

endpackage

// File: rtl/psh_operand_decode.sv
module psh_operand_decode #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4,
  parameter logic [DATA_W-1:0] OPCODE = 8'h7E
) (
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] operand,
  output logic              hit,
  output logic [IDX_W-1:0]  top_idx,
  output logic [IDX_W-1:0]  span
);
  logic [IDX_W-1:0] base_idx;

  // upper field names the lowest register, lower field the run length minus one
  assign base_idx = operand[2*IDX_W-1:IDX_W];
  assign span     = operand[IDX_W-1:0];
  assign hit      = (opcode == OPCODE);
  // index arithmetic wraps inside the register file
  assign top_idx  = base_idx + span;
endmodule

// File: rtl/psh_byte_source.sv
module psh_byte_source #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned SP_HI_IDX = 12,
  parameter int unsigned SP_LO_IDX = 13
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   rf_byte,
  input  logic [2*DATA_W-1:0] snap,
  output logic [DATA_W-1:0]   byte_out
);
  localparam logic [IDX_W-1:0] HI_SLOT = IDX_W'(SP_HI_IDX);
  localparam logic [IDX_W-1:0] LO_SLOT = IDX_W'(SP_LO_IDX);

  always_comb begin
    if (idx == HI_SLOT)      byte_out = snap[2*DATA_W-1:DATA_W];
    else if (idx == LO_SLOT) byte_out = snap[DATA_W-1:0];
    else                     byte_out = rf_byte;
  end
endmodule

// File: rtl/psh_sp_track.sv
module psh_sp_track #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [ADDR_W-1:0] snap,
  output logic [ADDR_W-1:0] cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      cur  <= '0;
    end else if (load) begin
      snap <= sp_in;
      cur  <= sp_in;
    end else if (step) begin
      cur  <= cur - ADDR_W'(1);
    end
  end
endmodule

// File: rtl/psh_multi_push.sv
module psh_multi_push
  import psh_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SP_HI_IDX = 12,
  parameter int unsigned SP_LO_IDX = 13,
  parameter logic [DATA_W-1:0] OPCODE = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_opcode,
  input  logic [DATA_W-1:0] cmd_operand,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic [ADDR_W-1:0] sp_rdata,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_wdata,
  output logic              mem_wr,
  input  logic              mem_wait,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              done
);
  localparam int unsigned SNAP_W = 2 * DATA_W;

  psh_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, left_q;
  logic [DATA_W-1:0] data_q;

  logic             op_hit;
  logic [IDX_W-1:0] dec_top, dec_span;
  logic             take, sp_load, sp_step;
  logic [ADDR_W-1:0] sp_snap, sp_cur;
  logic [DATA_W-1:0] src_byte;
  logic             byte_done, last_byte;

  psh_operand_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OPCODE(OPCODE)) u_dec (
    .opcode  (cmd_opcode),
    .operand (cmd_operand),
    .hit     (op_hit),
    .top_idx (dec_top),
    .span    (dec_span)
  );

  psh_sp_track #(.ADDR_W(ADDR_W)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sp_load),
    .step  (sp_step),
    .sp_in (sp_rdata),
    .snap  (sp_snap),
    .cur   (sp_cur)
  );

  psh_byte_source #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .SP_HI_IDX(SP_HI_IDX), .SP_LO_IDX(SP_LO_IDX)
  ) u_src (
    .idx      (idx_q),
    .rf_byte  (rf_rdata),
    .snap     (sp_snap[SNAP_W-1:0]),
    .byte_out (src_byte)
  );

  assign cmd_ready = (state_q == PS_IDLE);
  assign take      = cmd_ready && cmd_valid;
  assign sp_load   = take && op_hit;
  assign sp_step   = (state_q == PS_FETCH);
  assign byte_done = (state_q == PS_WRITE) && !mem_wait;
  assign last_byte = (left_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:   if (sp_load) state_d = PS_FETCH;
      PS_FETCH:  state_d = PS_WRITE;
      PS_WRITE:  if (byte_done) state_d = last_byte ? PS_RETIRE : PS_FETCH;
      PS_RETIRE: state_d = PS_IDLE;
      default:   state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      idx_q   <= '0;
      left_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (sp_load) begin
        idx_q  <= dec_top;
        left_q <= dec_span;
      end else if (byte_done && !last_byte) begin
        idx_q  <= idx_q - IDX_W'(1);
        left_q <= left_q - IDX_W'(1);
      end
      if (state_q == PS_FETCH) data_q <= src_byte;
    end
  end

  assign rf_raddr = idx_q;
  assign mem_wr   = (state_q == PS_WRITE);
  assign mem_addr = sp_cur;
  assign mem_data = data_q;
  assign sp_we    = (state_q == PS_RETIRE);
  assign sp_wdata = sp_cur;
  assign done     = (state_q == PS_RETIRE);
endmodule

// File: rtl/psh_multi_push_chk.sv
module psh_multi_push_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [DATA_W-1:0] OPCODE = 8'h7E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_opcode,
  input logic              sp_we,
  input logic [ADDR_W-1:0] sp_wdata,
  input logic              mem_wr,
  input logic              mem_wait,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              done
);
  logic              seen_wr;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_wr   <= 1'b0;
      last_addr <= '0;
    end else if (cmd_valid && cmd_ready) begin
      seen_wr   <= 1'b0;
    end else if (mem_wr && !mem_wait) begin
      seen_wr   <= 1'b1;
      last_addr <= mem_addr;
    end
  end

  // R8
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_wait) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_wait && seen_wr) |-> (mem_addr == last_addr - ADDR_W'(1)));

  // R9
  sp_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (seen_wr && sp_wdata == last_addr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  // R1
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_opcode == OPCODE) |=> !cmd_ready);

  // R2
  foreign_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_opcode != OPCODE) |=> (cmd_ready && !mem_wr && !sp_we));
endmodule

bind psh_multi_push psh_multi_push_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPCODE(OPCODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_opcode (cmd_opcode),
  .sp_we      (sp_we),
  .sp_wdata   (sp_wdata),
  .mem_wr     (mem_wr),
  .mem_wait   (mem_wait),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .done       (done)
);

// File: tb/psh_multi_push_tb.sv
module psh_multi_push_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = 8'h00;
  logic [7:0]  cmd_operand = 8'h00;
  logic [3:0]  rf_raddr;
  logic [7:0]  rf_rdata;
  logic [15:0] sp_rdata = 16'h0000;
  logic        sp_we;
  logic [15:0] sp_wdata;
  logic        mem_wr;
  logic        mem_wait = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  psh_multi_push u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_operand(cmd_operand), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .sp_rdata(sp_rdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .mem_wr(mem_wr), .mem_wait(mem_wait), .mem_addr(mem_addr), .mem_data(mem_data),
    .done(done)
  );

  // register file model: marker value at the stack-pointer slots
  function automatic logic [7:0] rf_val(input logic [3:0] i);
    if (i == 4'd12 || i == 4'd13) return 8'hEE;
    return 8'hA0 + {4'h0, i};
  endfunction
  assign rf_rdata = rf_val(rf_raddr);

  // memory stall pattern
  logic       wait_mode = 1'b0;
  logic [4:0] lfsr = 5'h13;
  always @(posedge clk) begin
    lfsr     <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    mem_wait <= wait_mode && lfsr[0] && lfsr[1];
  end

  // write log sampled away from the clock edge
  logic [15:0] log_addr [32];
  logic [7:0]  log_data [32];
  int          wr_cnt = 0;
  int          done_cnt = 0;
  int          hold_err = 0;
  logic [15:0] sp_seen = 16'h0;
  logic        held = 1'b0;
  logic [15:0] held_addr = 16'h0;
  logic [7:0]  held_data = 8'h0;

  always @(negedge clk) begin
    if (held && !(mem_wr && mem_addr == held_addr && mem_data == held_data)) hold_err++;
    held = 1'b0;
    if (mem_wr && mem_wait) begin
      held = 1'b1; held_addr = mem_addr; held_data = mem_data;
    end
    if (mem_wr && !mem_wait) begin
      if (wr_cnt < 32) begin
        log_addr[wr_cnt] = mem_addr;
        log_data[wr_cnt] = mem_data;
      end
      wr_cnt++;
    end
    if (done) begin
      done_cnt++;
      if (sp_we) sp_seen = sp_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_cnt = 0; done_cnt = 0; hold_err = 0; sp_seen = 16'h0;
  endtask

  task automatic issue(input logic [7:0] opc, input logic [7:0] opr, input logic [15:0] sp0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = opc; cmd_operand = opr; sp_rdata = sp0;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done_cnt != 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input logic [3:0] base, input logic [3:0] span,
                        input logic [15:0] sp0, input string tag);
    int n;
    n = int'(span) + 1;
    check(wr_cnt == n, {tag, " R3 write count"}, wr_cnt, n);
    for (int k = 0; k < n && k < wr_cnt; k++) begin
      logic [3:0]  ix;
      logic [7:0]  ed;
      logic [15:0] ea;
      ix = base + span - 4'(k);
      ea = sp0 - 16'(k + 1);
      ed = (ix == 4'd12) ? sp0[15:8] : (ix == 4'd13) ? sp0[7:0] : rf_val(ix);
      check(log_addr[k] == ea, {tag, " R5 address"}, log_addr[k], ea);
      check(log_data[k] == ed, {tag, " R4/R6/R7 data order"}, log_data[k], ed);
    end
    check(done_cnt == 1, {tag, " R9 done pulse count"}, done_cnt, 1);
    check(sp_seen == sp0 - 16'(n), {tag, " R9 final stack pointer"}, sp_seen, sp0 - 16'(n));
    check(hold_err == 0, {tag, " R8 held request"}, hold_err, 0);
  endtask

  // {base, count-1, SP0, stall mode}
  localparam logic [31:0] VECS [6] = '{
    {4'd2,  4'd0,  16'h8000, 8'd0},   // single register
    {4'd0,  4'd15, 16'h4000, 8'd1},   // all 16, includes SP slots
    {4'd14, 4'd3,  16'h0002, 8'd1},   // R7 wrap, address wrap too
    {4'd10, 4'd5,  16'h1234, 8'd0},   // R6 range holding both SP slots
    {4'd13, 4'd0,  16'hABCD, 8'd1},   // only the low SP slot
    {4'd5,  4'd15, 16'hF00F, 8'd1}    // full wrap from mid file
  };

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    join_none

    // R10 reset state
    repeat (2) @(negedge clk);
    check(cmd_ready == 1'b1 && mem_wr == 1'b0 && sp_we == 1'b0 && done == 1'b0,
          "R10 outputs in reset", {cmd_ready, mem_wr, sp_we, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && mem_wr == 1'b0 && done == 1'b0,
          "R10 outputs after reset", {cmd_ready, mem_wr, done}, 3'b100);

    foreach (VECS[v]) begin
      logic [3:0]  b, s;
      logic [15:0] sp0;
      b = VECS[v][31:28]; s = VECS[v][27:24]; sp0 = VECS[v][23:8];
      wait_mode = VECS[v][0];
      clear_log();
      issue(8'h7E, {b, s}, sp0);
      wait_done();
      verify(b, s, sp0, $sformatf("vec%0d", v));
    end
    wait_mode = 1'b0;

    // R2 foreign opcode is dropped
    clear_log();
    issue(8'h7D, 8'h03, 16'h2000);
    repeat (20) @(negedge clk);
    check(wr_cnt == 0 && done_cnt == 0, "R2 foreign opcode activity", wr_cnt + done_cnt, 0);
    check(cmd_ready == 1'b1, "R2 still idle", cmd_ready, 1);

    // R1 command held during a push is not taken
    clear_log();
    issue(8'h7E, 8'h42, 16'h3000);
    @(negedge clk);
    check(cmd_ready == 1'b0, "R1 busy drops ready", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_opcode = 8'h7E; cmd_operand = 8'h00; sp_rdata = 16'h5555;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0; sp_rdata = 16'h3000;
    wait_done();
    repeat (20) @(negedge clk);
    verify(4'd4, 4'd2, 16'h3000, "R1 busy");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule